// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block turns one read or write command at a time into the four-phase enable/acknowledge handshake used by a PHY's parallel control-register port. A write sets up the address and data, raises the write strobe, waits for the acknowledge to rise, drops the strobe and waits for the acknowledge to fall. A read does the same with the read strobe, and it captures the PHY's read data in the cycle where the acknowledge is first seen high.

Each of the two acknowledge waits has its own bound. A free-running one-microsecond tick input is divided into poll intervals, and a wait that lasts `POLL_LIMIT` intervals ends the transaction. The strobe is dropped and the response carries a status code that tells whether the rising or the falling edge of the acknowledge was missed. Commands enter through a valid/ready pair. The response is a one-cycle strobe with a status code, plus a read-data register that holds its value between reads.

Top module: `phy_cr_master`

## Requirements
- R1: `cmd_ready` is high only in idle. A command is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` then stays low until the cycle after the response strobe.
- R2: The address, and for a write also the data, appear on `phy_addr`/`phy_wdata` at least one cycle before the strobe rises. They stay unchanged while the strobe is high.
- R3: A strobe stays high until `phy_ack` is sampled high and then drops on the next edge. A successful response is given only after `phy_ack` has been sampled low again.
- R4: A write uses only `phy_wr_en` and a read uses only `phy_rd_en`. The two strobes are never high together.
- R5: A read samples `phy_rdata` in the cycle where `phy_ack` is first seen high. That value appears on `rsp_rdata` no later than the response strobe.
- R6: If `phy_ack` does not rise within `POLL_LIMIT`×`TICKS_PER_POLL` ticks of `tick_us`, the strobe is dropped and the response has `rsp_status` = 2'b01.
- R7: If `phy_ack` does not fall within the same bound after the strobe drops, the response has `rsp_status` = 2'b10.
- R8: A transaction that completes both edges responds with `rsp_status` = 2'b00. `rsp_valid` is high for exactly one cycle per accepted command.
- R9: `rsp_rdata` changes only when a read captures data. Writes and reads that time out on the rising edge leave it unchanged. A read that times out on the falling edge still updates it.
- R10: While `rst_n` is low, both strobes and `rsp_valid` are low and `cmd_ready` is high. `rsp_rdata` is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 00 ok, 01 rise timeout, 10 fall timeout |
| rsp_rdata | output | DATA_W | Last captured read data |
| phy_addr | output | ADDR_W | Address to PHY |
| phy_wdata | output | DATA_W | Write data to PHY |
| phy_wr_en | output | 1 | Write strobe |
| phy_rd_en | output | 1 | Read strobe |
| phy_rdata | input | DATA_W | Read data from PHY |
| phy_ack | input | 1 | PHY acknowledge |

## Verification
The assertions assume that `phy_ack` is a synchronous input and that a new command is never presented while `cmd_ready` is low. The bench changes command fields only at idle. Its PHY model drives the acknowledge from registers on the rising clock edge and lets it rise only after a strobe rises. The timeout cases use a PHY model that holds the acknowledge low or high on purpose. These cases come after random acknowledge delays that stay well inside the bound, and after one delay placed close to the bound.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RISE  = 3'd2,
    ST_FALL  = 3'd3,
    ST_RESP  = 3'd4
  } cr_state_e;

  localparam logic [1:0] STAT_OK      = 2'b00;
  localparam logic [1:0] STAT_RISE_TO = 2'b01;
  localparam logic [1:0] STAT_FALL_TO = 2'b10;
endpackage

// File: rtl/cr_poll_timer.sv
module cr_poll_timer #(
  parameter int TICKS_PER_POLL = 10,
  parameter int POLL_LIMIT     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int TW = (TICKS_PER_POLL > 1) ? $clog2(TICKS_PER_POLL) : 1;
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_POLL - 1);
  localparam logic [PW-1:0] POLL_MAX  = PW'(POLL_LIMIT);

  logic [TW-1:0] tick_q, tick_d;
  logic [PW-1:0] poll_q, poll_d;
  logic          cnt_en;

  assign expired = (poll_q == POLL_MAX);
  assign cnt_en  = clr | (tick & ~expired);

  always_comb begin
    tick_d = tick_q;
    poll_d = poll_q;
    if (clr) begin
      tick_d = '0;
      poll_d = '0;
    end else if (tick_q == TICK_LAST) begin
      tick_d = '0;
      poll_d = poll_q + PW'(1);
    end else begin
      tick_d = tick_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (cnt_en) begin
      tick_q <= tick_d;
      poll_q <= poll_d;
    end
  end

  assert_poll_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= POLL_MAX);
  assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expired);
endmodule

// File: rtl/cr_hs_fsm.sv
module cr_hs_fsm
  import phy_cr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  input  logic              phy_ack,
  input  logic              expired,
  output logic              timer_clr,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_wr_en,
  output logic              phy_rd_en,
  output logic              rd_capture,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status
);
  cr_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic [1:0]        stat_q, stat_d;
  logic              accept;
  logic              strobe;

  assign accept = (state_q == ST_IDLE) & cmd_valid;
  assign strobe = (state_q == ST_RISE);

  always_comb begin
    state_d = state_q;
    stat_d  = stat_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) begin
                  state_d = ST_SETUP;
                  stat_d  = STAT_OK;
                end
      ST_SETUP: state_d = ST_RISE;
      ST_RISE:  if (phy_ack) begin
                  state_d = ST_FALL;
                end else if (expired) begin
                  state_d = ST_RESP;
                  stat_d  = STAT_RISE_TO;
                end
      ST_FALL:  if (!phy_ack) begin
                  state_d = ST_RESP;
                end else if (expired) begin
                  state_d = ST_RESP;
                  stat_d  = STAT_FALL_TO;
                end
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stat_q  <= STAT_OK;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
      wr_q    <= cmd_write;
    end
  end

  assign timer_clr  = (state_d != state_q);
  assign cmd_ready  = (state_q == ST_IDLE);
  assign phy_addr   = addr_q;
  assign phy_wdata  = wdata_q;
  assign phy_wr_en  = strobe & wr_q;
  assign phy_rd_en  = strobe & ~wr_q;
  assign rd_capture = strobe & ~wr_q & phy_ack;
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_status = stat_q;

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_wr_en && phy_rd_en));
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wr_en || phy_rd_en) |-> ($stable(phy_addr) && $stable(phy_wdata)));
  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_wr_en || phy_rd_en) && !phy_ack && !expired) |=> (phy_wr_en || phy_rd_en));
  assert_drop_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_wr_en || phy_rd_en) && phy_ack) |=> !(phy_wr_en || phy_rd_en));
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_ok_after_unack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FALL && phy_ack && !expired) |=> !rsp_valid);
endmodule

// File: rtl/cr_rdata_hold.sv
module cr_rdata_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (capture) data_q <= din;
  end

  assign dout = data_q;

  assert_rdata_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(dout));
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master #(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter int TICKS_PER_POLL = 10,
  parameter int POLL_LIMIT     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_wr_en,
  output logic              phy_rd_en,
  input  logic [DATA_W-1:0] phy_rdata,
  input  logic              phy_ack
);
  logic timer_clr;
  logic expired;
  logic rd_capture;

  cr_poll_timer #(
    .TICKS_PER_POLL(TICKS_PER_POLL),
    .POLL_LIMIT    (POLL_LIMIT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (timer_clr),
    .tick   (tick_us),
    .expired(expired)
  );

  cr_hs_fsm #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_ready (cmd_ready),
    .phy_ack   (phy_ack),
    .expired   (expired),
    .timer_clr (timer_clr),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_wr_en (phy_wr_en),
    .phy_rd_en (phy_rd_en),
    .rd_capture(rd_capture),
    .rsp_valid (rsp_valid),
    .rsp_status(rsp_status)
  );

  cr_rdata_hold #(
    .DATA_W(DATA_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(rd_capture),
    .din    (phy_rdata),
    .dout   (rsp_rdata)
  );
endmodule

// File: tb/sim_phy_cr_master.sv
`timescale 1ns/1ps
module sim_phy_cr_master;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_us = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] phy_addr;
  logic [DW-1:0] phy_wdata;
  logic          phy_wr_en, phy_rd_en;
  logic [DW-1:0] phy_rdata = '0;
  logic          phy_ack = 1'b0;

  int checks = 0;
  int fails  = 0;

  // PHY model controls
  int rise_dly = 0;
  int fall_dly = 0;
  bit stuck_lo = 0;
  bit stuck_hi = 0;
  int pcnt = 0;
  int tdiv = 0;

  // expected command
  bit            exp_wr;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_wdata;
  logic [DW-1:0] model_rdata = '0;

  always #4 clk = ~clk;

  phy_cr_master u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_wr_en(phy_wr_en), .phy_rd_en(phy_rd_en),
    .phy_rdata(phy_rdata), .phy_ack(phy_ack)
  );

  function automatic logic [DW-1:0] reg_value(input logic [AW-1:0] a);
    return (a * 16'd37) ^ 16'hA55A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick every 4 clocks
  always @(posedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    tick_us <= (tdiv == 3);
  end

  // PHY model
  always @(posedge clk) begin
    logic en;
    en = phy_wr_en | phy_rd_en;
    phy_rdata <= reg_value(phy_addr);
    if (en && !phy_ack && !stuck_lo) begin
      if (pcnt >= rise_dly) begin phy_ack <= 1'b1; pcnt <= 0; end
      else pcnt <= pcnt + 1;
    end else if (!en && phy_ack && !stuck_hi) begin
      if (pcnt >= fall_dly) begin phy_ack <= 1'b0; pcnt <= 0; end
      else pcnt <= pcnt + 1;
    end else begin
      pcnt <= 0;
    end
  end

  // strobe monitor
  bit prev_wr = 0, prev_rd = 0, prev_ack = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (phy_wr_en && phy_rd_en)
        check(0, "R4", 3, 1);
      if ((phy_wr_en && !prev_wr) || (phy_rd_en && !prev_rd)) begin
        check(phy_wr_en == exp_wr && phy_rd_en == !exp_wr, "R4",
              {phy_wr_en, phy_rd_en}, {exp_wr, !exp_wr});
        check(phy_addr == exp_addr, "R2", phy_addr, exp_addr);
        if (exp_wr) check(phy_wdata == exp_wdata, "R2", phy_wdata, exp_wdata);
      end
      if (prev_ack && phy_ack && (phy_wr_en || phy_rd_en))
        check(0, "R3", 1, 0);
    end
    prev_wr  = phy_wr_en;
    prev_rd  = phy_rd_en;
    prev_ack = phy_ack;
  end

  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [1:0] st, output logic [DW-1:0] rd);
    int n;
    @(negedge clk);
    exp_wr = wr; exp_addr = a; exp_wdata = d;
    check(cmd_ready == 1'b1, "R1", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R1", cmd_ready, 0);
    n = 0;
    while (!rsp_valid && n < 2000) begin
      if (cmd_ready) begin check(0, "R1", 1, 0); break; end
      @(negedge clk); n++;
    end
    st = rsp_status; rd = rsp_rdata;
    check(rsp_valid == 1'b1, "R8", rsp_valid, 1);
    if (st == 2'b00) check(phy_ack == 1'b0, "R3", phy_ack, 0);
    check(!(phy_wr_en || phy_rd_en), "R6", {phy_wr_en, phy_rd_en}, 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", rsp_valid, 0);
    check(cmd_ready == 1'b1, "R1", cmd_ready, 1);
  endtask

  initial begin
    #200000000;
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0]    st;
    logic [DW-1:0] rd;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(cmd_ready == 1'b1, "R10", cmd_ready, 1);
    check(!phy_wr_en && !phy_rd_en, "R10", {phy_wr_en, phy_rd_en}, 0);
    check(rsp_valid == 1'b0, "R10", rsp_valid, 0);
    check(rsp_rdata == '0, "R10", rsp_rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed write then read (R2,R3,R5,R8)
    rise_dly = 3; fall_dly = 2;
    run_txn(1'b1, 16'h0042, 16'hBEEF, st, rd);
    check(st == 2'b00, "R8", st, 0);
    check(rd == model_rdata, "R9", rd, model_rdata);
    run_txn(1'b0, 16'h0100, 16'h0, st, rd);
    model_rdata = reg_value(16'h0100);
    check(st == 2'b00, "R8", st, 0);
    check(rd == model_rdata, "R5", rd, model_rdata);

    // zero delays
    rise_dly = 0; fall_dly = 0;
    run_txn(1'b0, 16'h7FFF, 16'h0, st, rd);
    model_rdata = reg_value(16'h7FFF);
    check(rd == model_rdata && st == 2'b00, "R5", rd, model_rdata);

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      wr = $urandom_range(0, 1);
      a  = AW'($urandom);
      d  = DW'($urandom);
      rise_dly = $urandom_range(0, 40);
      fall_dly = $urandom_range(0, 40);
      run_txn(wr, a, d, st, rd);
      if (!wr) model_rdata = reg_value(a);
      check(st == 2'b00, "R8", st, 0);
      check(rd == model_rdata, wr ? "R9" : "R5", rd, model_rdata);
    end

    // ack close to the bound (95 of 100 ticks) still succeeds
    rise_dly = 376; fall_dly = 1;
    run_txn(1'b0, 16'h0ABC, 16'h0, st, rd);
    model_rdata = reg_value(16'h0ABC);
    check(st == 2'b00, "R6", st, 0);
    check(rd == model_rdata, "R5", rd, model_rdata);

    // rise timeout on read: data unchanged
    stuck_lo = 1; rise_dly = 0; fall_dly = 0;
    run_txn(1'b0, 16'h0555, 16'h0, st, rd);
    check(st == 2'b01, "R6", st, 1);
    check(rd == model_rdata, "R9", rd, model_rdata);
    // rise timeout on write
    run_txn(1'b1, 16'h0666, 16'h1234, st, rd);
    check(st == 2'b01, "R6", st, 1);
    stuck_lo = 0;

    // fall timeout on write
    stuck_hi = 1;
    run_txn(1'b1, 16'h0777, 16'h4321, st, rd);
    check(st == 2'b10, "R7", st, 2);
    check(rd == model_rdata, "R9", rd, model_rdata);
    stuck_hi = 0;
    repeat (4) @(negedge clk);

    // fall timeout on read: data still updated
    stuck_hi = 1;
    run_txn(1'b0, 16'h0888, 16'h0, st, rd);
    model_rdata = reg_value(16'h0888);
    check(st == 2'b10, "R7", st, 2);
    check(rd == model_rdata, "R9", rd, model_rdata);
    stuck_hi = 0;
    repeat (4) @(negedge clk);

    // recovery after timeouts
    run_txn(1'b0, 16'h0999, 16'h0, st, rd);
    model_rdata = reg_value(16'h0999);
    check(st == 2'b00 && rd == model_rdata, "R8", rd, model_rdata);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule